// File: doc/BRIEF.md
# Asymmetric Pipe Slotting Unit

This block sits after decode in an in-order superscalar front end. Every cycle it looks at up to four decoded instructions in program order. Each instruction carries an operation-class code and a width bit. The block places each instruction on one of four execution pipes: two integer pipes (E0, E1), a floating-point adder pipe (FA) and a floating-point multiplier pipe (FM). The pipes are not interchangeable. Some classes are tied to one pipe, and others may use either of two pipes. Loads and stores exclude each other within a cycle. Placement runs strictly in order and halts at the first instruction that cannot be placed. That instruction and every later one wait for a following cycle.

The integer multiplier and the floating divider are not pipelined. Each is guarded by a small two-state machine, `unit_timer`, with states UT_IDLE and UT_BUSY. The START transition (UT_IDLE to UT_BUSY) is taken when an instruction for that unit issues. In UT_BUSY the timer loads the hold length minus one and counts down. The EXPIRE transition (UT_BUSY to UT_IDLE) is taken when the count runs out. The RESET transition returns the timer to UT_IDLE from either state. While a unit's timer is in UT_BUSY, no new instruction for that unit can be placed. The outputs are an issue mask and a 2-bit pipe code per slot, both combinational in the current cycle.

Top module: `pipe_slotter`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `issue_o` is all zero. After reset both unit timers are idle, so a multiply or divide presented right after reset issues at once.
- R2: Pipe codes are E0=0, E1=1, FA=2, FM=3. Store (5), shift (6), multimedia (7) and integer multiply (8) go only to E0. Integer branch (9) and call (10) go only to E1.
- R3: Integer add (0), logic (1), compare (2), conditional move (3) and load (4) take E0 when it is free and E1 otherwise.
- R4: Two loads may issue in one cycle. A load and a store never issue in the same cycle; whichever comes later in order is held.
- R5: FP add (11), FP conditional move (12), FP branch (13) and FP divide (14) go only to FA. FP multiply (15) goes only to FM. FP copy-sign (16) takes FM when it is free and FA otherwise.
- R6: Class multi (17) takes all four pipes. It issues only from slot 0, and then it is the only slot issued. In any later slot it cannot be placed.
- R7: After an integer multiply issues, the next multiply can issue no earlier than 4 cycles later when its width bit was 0, or 8 cycles later when it was 1.
- R8: `issue_o` always has the form of contiguous ones from slot 0. An invalid slot, an unknown class code (18 to 31), or any slot that cannot be placed stops issue for itself and for all later slots.
- R9: After an FP divide issues, the next divide can issue no earlier than 15 cycles later (width 0) or 22 cycles later (width 1). A busy divider does not block other FA or FM work that comes ahead of the held divide.
- R10: No two issued slots share a pipe. A slot that is not issued reports pipe code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_vld_i | input | 4 | Per-slot valid; bit 0 is the oldest instruction |
| slot_cls_i | input | 20 | Per-slot 5-bit class code; slot s at bits [5s+4:5s] |
| slot_wide_i | input | 4 | Per-slot width: 64-bit multiply or double-precision divide when 1 |
| issue_o | output | 4 | Per-slot issue mask for this cycle |
| pipe_o | output | 8 | Per-slot pipe code; slot s at bits [2s+1:2s] |

## Verification
A timer stuck in UT_BUSY shows up in the first cycle a multiply or divide is offered after its window should have closed: the slot stays low in `issue_o`. A timer that leaves UT_BUSY early lets a multiply or divide issue one cycle or more before its spacing allows, so hold lengths are probed cycle by cycle at both widths. A corrupted occupancy or load/store flag inside the placement chain is visible in the same cycle, as a shared pipe code, a wrongly held later slot, or a load and a store issued together.

// File: rtl/slot_pkg.sv
`timescale 1ns/1ps
package slot_pkg;
    localparam int CLS_W  = 5;
    localparam int NPIPES = 4;
    localparam int PIPE_W = 2;

    typedef enum logic [CLS_W-1:0] {
        OP_IADD  = 5'd0,  OP_ILOG  = 5'd1,  OP_ICMP  = 5'd2,  OP_ICMOV = 5'd3,
        OP_LOAD  = 5'd4,  OP_STORE = 5'd5,  OP_SHIFT = 5'd6,  OP_MEDIA = 5'd7,
        OP_IMUL  = 5'd8,  OP_IBR   = 5'd9,  OP_CALL  = 5'd10, OP_FADD  = 5'd11,
        OP_FCMOV = 5'd12, OP_FBR   = 5'd13, OP_FDIV  = 5'd14, OP_FMUL  = 5'd15,
        OP_FCPYS = 5'd16, OP_MULTI = 5'd17
    } op_class_e;

    typedef enum logic [PIPE_W-1:0] {
        PIPE_E0 = 2'd0, PIPE_E1 = 2'd1, PIPE_FA = 2'd2, PIPE_FM = 2'd3
    } pipe_e;

    typedef struct packed {
        logic              legal;
        logic [NPIPES-1:0] allow;
        pipe_e             pref;
        logic              is_load;
        logic              is_store;
        logic              is_mul;
        logic              is_div;
        logic              is_multi;
    } slot_need_t;

    function automatic pipe_e lowest_pipe(input logic [NPIPES-1:0] m);
        pipe_e r;
        r = PIPE_E0;
        for (int i = NPIPES - 1; i >= 0; i--) begin
            if (m[i]) r = pipe_e'(PIPE_W'(i));
        end
        return r;
    endfunction
endpackage

// File: rtl/slot_decode.sv
`timescale 1ns/1ps
module slot_decode
    import slot_pkg::*;
(
    input  logic [CLS_W-1:0] cls_i,
    output slot_need_t       need_o
);
    localparam logic [NPIPES-1:0] M_E0   = 4'b0001;
    localparam logic [NPIPES-1:0] M_E1   = 4'b0010;
    localparam logic [NPIPES-1:0] M_FA   = 4'b0100;
    localparam logic [NPIPES-1:0] M_FM   = 4'b1000;
    localparam logic [NPIPES-1:0] M_INT  = M_E0 | M_E1;
    localparam logic [NPIPES-1:0] M_FP   = M_FA | M_FM;

    always_comb begin
        need_o       = '0;
        need_o.legal = 1'b1;
        need_o.pref  = PIPE_E0;
        unique case (cls_i)
            OP_IADD, OP_ILOG, OP_ICMP, OP_ICMOV: need_o.allow = M_INT;
            OP_LOAD: begin
                need_o.allow   = M_INT;
                need_o.is_load = 1'b1;
            end
            OP_STORE: begin
                need_o.allow    = M_E0;
                need_o.is_store = 1'b1;
            end
            OP_SHIFT, OP_MEDIA: need_o.allow = M_E0;
            OP_IMUL: begin
                need_o.allow  = M_E0;
                need_o.is_mul = 1'b1;
            end
            OP_IBR, OP_CALL: begin
                need_o.allow = M_E1;
                need_o.pref  = PIPE_E1;
            end
            OP_FADD, OP_FCMOV, OP_FBR: begin
                need_o.allow = M_FA;
                need_o.pref  = PIPE_FA;
            end
            OP_FDIV: begin
                need_o.allow  = M_FA;
                need_o.pref   = PIPE_FA;
                need_o.is_div = 1'b1;
            end
            OP_FMUL: begin
                need_o.allow = M_FM;
                need_o.pref  = PIPE_FM;
            end
            OP_FCPYS: begin
                need_o.allow = M_FP;
                need_o.pref  = PIPE_FM;
            end
            OP_MULTI: begin
                need_o.allow    = '1;
                need_o.is_multi = 1'b1;
            end
            default: need_o.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/unit_timer.sv
`timescale 1ns/1ps
module unit_timer #(
    parameter int SHORT_HOLD = 4,
    parameter int LONG_HOLD  = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic wide_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(LONG_HOLD + 1);
    localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(SHORT_HOLD - 1);
    localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(LONG_HOLD - 1);

    typedef enum logic {UT_IDLE, UT_BUSY} ut_state_e;

    ut_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: START, EXPIRE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            UT_IDLE: begin
                if (start_i) begin
                    state_d = UT_BUSY;
                    cnt_d   = wide_i ? LONG_LOAD : SHORT_LOAD;
                end
            end
            UT_BUSY: begin
                if (cnt_q <= CNT_W'(1)) begin
                    state_d = UT_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: state_d = UT_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (state_q == UT_BUSY);
    end
endmodule

// File: rtl/slot_router.sv
`timescale 1ns/1ps
module slot_router
    import slot_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic [SLOTS-1:0]                vld_i,
    input  slot_need_t [SLOTS-1:0]          need_i,
    input  logic [SLOTS-1:0]                wide_i,
    input  logic                            mul_busy_i,
    input  logic                            div_busy_i,
    output logic [SLOTS-1:0]                issue_o,
    output logic [SLOTS*PIPE_W-1:0]         pipe_o,
    output logic                            mul_start_o,
    output logic                            mul_wide_o,
    output logic                            div_start_o,
    output logic                            div_wide_o
);
    always_comb begin
        logic [NPIPES-1:0] taken;
        logic [NPIPES-1:0] pref_m;
        logic [NPIPES-1:0] free_m;
        logic [NPIPES-1:0] alt_m;
        logic              ld_seen, st_seen, halted, ok;
        logic              mul_seen, mul_w, div_seen, div_w;
        pipe_e             pick;

        taken    = '0;
        ld_seen  = 1'b0;
        st_seen  = 1'b0;
        halted   = 1'b0;
        mul_seen = 1'b0;
        mul_w    = 1'b0;
        div_seen = 1'b0;
        div_w    = 1'b0;
        issue_o  = '0;
        pipe_o   = '0;

        for (int s = 0; s < SLOTS; s++) begin
            pref_m = NPIPES'(1) << need_i[s].pref;
            free_m = need_i[s].allow & ~taken;
            alt_m  = free_m & ~pref_m;
            pick   = need_i[s].pref;
            ok     = vld_i[s] && need_i[s].legal && !halted;

            if (need_i[s].is_multi) begin
                pick = PIPE_E0;
                if (taken != '0) ok = 1'b0;
            end else if ((free_m & pref_m) != '0) begin
                pick = need_i[s].pref;
            end else if (alt_m != '0) begin
                pick = lowest_pipe(alt_m);
            end else begin
                ok = 1'b0;
            end

            if (need_i[s].is_load && st_seen) ok = 1'b0;
            if (need_i[s].is_store && ld_seen) ok = 1'b0;
            if (need_i[s].is_mul && (mul_busy_i || mul_seen)) ok = 1'b0;
            if (need_i[s].is_div && (div_busy_i || div_seen)) ok = 1'b0;

            if (ok) begin
                issue_o[s]                 = 1'b1;
                pipe_o[s*PIPE_W +: PIPE_W] = pick;
                if (need_i[s].is_multi) taken = '1;
                else                    taken = taken | (NPIPES'(1) << pick);
                ld_seen = ld_seen | need_i[s].is_load;
                st_seen = st_seen | need_i[s].is_store;
                if (need_i[s].is_mul) begin
                    mul_seen = 1'b1;
                    mul_w    = wide_i[s];
                end
                if (need_i[s].is_div) begin
                    div_seen = 1'b1;
                    div_w    = wide_i[s];
                end
            end else begin
                halted = 1'b1;
            end
        end

        mul_start_o = mul_seen;
        mul_wide_o  = mul_w;
        div_start_o = div_seen;
        div_wide_o  = div_w;
    end
endmodule

// File: rtl/pipe_slotter.sv
`timescale 1ns/1ps
module pipe_slotter
    import slot_pkg::*;
#(
    parameter int SLOTS      = 4,
    parameter int MUL_SHORT  = 4,
    parameter int MUL_LONG   = 8,
    parameter int DIV_SHORT  = 15,
    parameter int DIV_LONG   = 22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SLOTS-1:0]        slot_vld_i,
    input  logic [SLOTS*CLS_W-1:0]  slot_cls_i,
    input  logic [SLOTS-1:0]        slot_wide_i,
    output logic [SLOTS-1:0]        issue_o,
    output logic [SLOTS*PIPE_W-1:0] pipe_o
);
    slot_need_t [SLOTS-1:0]  need;
    logic [SLOTS-1:0]        issue_raw;
    logic [SLOTS*PIPE_W-1:0] pipe_raw;
    logic mul_busy, div_busy;
    logic mul_start, mul_wide, div_start, div_wide;

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        slot_decode u_dec (
            .cls_i  (slot_cls_i[g*CLS_W +: CLS_W]),
            .need_o (need[g])
        );
    end

    slot_router #(.SLOTS(SLOTS)) u_router (
        .vld_i       (slot_vld_i),
        .need_i      (need),
        .wide_i      (slot_wide_i),
        .mul_busy_i  (mul_busy),
        .div_busy_i  (div_busy),
        .issue_o     (issue_raw),
        .pipe_o      (pipe_raw),
        .mul_start_o (mul_start),
        .mul_wide_o  (mul_wide),
        .div_start_o (div_start),
        .div_wide_o  (div_wide)
    );

    unit_timer #(.SHORT_HOLD(MUL_SHORT), .LONG_HOLD(MUL_LONG)) u_mul_tmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (mul_start),
        .wide_i  (mul_wide),
        .busy_o  (mul_busy)
    );

    unit_timer #(.SHORT_HOLD(DIV_SHORT), .LONG_HOLD(DIV_LONG)) u_div_tmr (
        .clk     (clk),
        .rst     (rst),
        .start_i (div_start),
        .wide_i  (div_wide),
        .busy_o  (div_busy)
    );

    always_comb begin
        issue_o = rst ? '0 : issue_raw;
        pipe_o  = rst ? '0 : pipe_raw;
    end
endmodule

// File: rtl/pipe_slotter_chk.sv
`timescale 1ns/1ps
module pipe_slotter_chk
    import slot_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int MUL_SHORT = 4,
    parameter int MUL_LONG  = 8,
    parameter int DIV_SHORT = 15,
    parameter int DIV_LONG  = 22
) (
    input logic                    clk,
    input logic                    rst,
    input logic [SLOTS-1:0]        slot_vld_i,
    input logic [SLOTS*CLS_W-1:0]  slot_cls_i,
    input logic [SLOTS-1:0]        slot_wide_i,
    input logic [SLOTS-1:0]        issue_o,
    input logic [SLOTS*PIPE_W-1:0] pipe_o
);
    localparam int GW = $clog2(DIV_LONG + 1);

    logic mul_fire, mul_w, div_fire, div_w;
    logic ld_any, st_any, route_bad, clash, multi_any, multi_late, idle_pipe_bad;
    logic [SLOTS:0] mask_inc;
    logic [GW-1:0] mul_gap, div_gap;

    always_comb begin
        logic [NPIPES-1:0] used;
        logic [CLS_W-1:0]  c;
        logic [PIPE_W-1:0] p;
        used = '0;
        mul_fire = 1'b0; mul_w = 1'b0; div_fire = 1'b0; div_w = 1'b0;
        ld_any = 1'b0; st_any = 1'b0; route_bad = 1'b0; clash = 1'b0;
        multi_any = 1'b0; multi_late = 1'b0; idle_pipe_bad = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            c = slot_cls_i[s*CLS_W +: CLS_W];
            p = pipe_o[s*PIPE_W +: PIPE_W];
            if (!issue_o[s]) begin
                if (p != '0) idle_pipe_bad = 1'b1;
            end else if (c == OP_MULTI) begin
                multi_any = 1'b1;
                if (s != 0) multi_late = 1'b1;
            end else begin
                if (used[p]) clash = 1'b1;
                used[p] = 1'b1;
                if (c == OP_LOAD)  ld_any = 1'b1;
                if (c == OP_STORE) st_any = 1'b1;
                if ((c == OP_STORE || c == OP_SHIFT || c == OP_MEDIA || c == OP_IMUL) && p != 2'd0)
                    route_bad = 1'b1;
                if ((c == OP_IBR || c == OP_CALL) && p != 2'd1) route_bad = 1'b1;
                if (c == OP_IMUL) begin mul_fire = 1'b1; mul_w = slot_wide_i[s]; end
                if (c == OP_FDIV) begin div_fire = 1'b1; div_w = slot_wide_i[s]; end
            end
        end
        mask_inc = {1'b0, issue_o} + (SLOTS+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mul_gap <= '0;
            div_gap <= '0;
        end else begin
            if (mul_fire)             mul_gap <= GW'(mul_w ? MUL_LONG - 1 : MUL_SHORT - 1);
            else if (mul_gap != '0)   mul_gap <= mul_gap - GW'(1);
            if (div_fire)             div_gap <= GW'(div_w ? DIV_LONG - 1 : DIV_SHORT - 1);
            else if (div_gap != '0)   div_gap <= div_gap - GW'(1);
        end
    end

    AST_RESET_SILENT: assert property (@(posedge clk) rst |-> issue_o == '0); // R1
    AST_FIXED_ROUTE:  assert property (@(posedge clk) disable iff (rst) !route_bad); // R2
    AST_LDST_APART:   assert property (@(posedge clk) disable iff (rst) !(ld_any && st_any)); // R4
    AST_MULTI_ALONE:  assert property (@(posedge clk) disable iff (rst) multi_any |-> (issue_o == SLOTS'(1) && !multi_late)); // R6
    AST_MUL_SPACING:  assert property (@(posedge clk) disable iff (rst) mul_fire |-> mul_gap == '0); // R7
    AST_IN_ORDER:     assert property (@(posedge clk) disable iff (rst) (mask_inc[SLOTS-1:0] & issue_o) == '0); // R8
    AST_DIV_SPACING:  assert property (@(posedge clk) disable iff (rst) div_fire |-> div_gap == '0); // R9
    AST_PIPE_UNIQUE:  assert property (@(posedge clk) disable iff (rst) !clash && !idle_pipe_bad); // R10
endmodule

bind pipe_slotter pipe_slotter_chk #(
    .SLOTS(SLOTS), .MUL_SHORT(MUL_SHORT), .MUL_LONG(MUL_LONG),
    .DIV_SHORT(DIV_SHORT), .DIV_LONG(DIV_LONG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_vld_i  (slot_vld_i),
    .slot_cls_i  (slot_cls_i),
    .slot_wide_i (slot_wide_i),
    .issue_o     (issue_o),
    .pipe_o      (pipe_o)
);

// File: tb/pipe_slotter_tb_top.sv
`timescale 1ns/1ps
module pipe_slotter_tb_top;
    import slot_pkg::*;

    localparam int WATCHDOG_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  vld = '0;
    logic [19:0] cls = '0;
    logic [3:0]  wide = '0;
    logic [3:0]  issue;
    logic [7:0]  pipe;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pipe_slotter dut_i (
        .clk         (clk),
        .rst         (rst),
        .slot_vld_i  (vld),
        .slot_cls_i  (cls),
        .slot_wide_i (wide),
        .issue_o     (issue),
        .pipe_o      (pipe)
    );

    task automatic clear_slots();
        vld = '0; cls = '0; wide = '0;
    endtask

    task automatic put(input int s, input logic [4:0] c, input logic w);
        vld[s]        = 1'b1;
        cls[s*5 +: 5] = c;
        wide[s]       = w;
    endtask

    task automatic expect_out(input string tag, input logic [3:0] ei, input logic [7:0] ep);
        #1;
        checks++;
        if (issue !== ei || pipe !== ep) begin
            errors++;
            $display("FAIL %s issue=%b pipe=%b expected issue=%b pipe=%b", tag, issue, pipe, ei, ep);
        end
    endtask

    task automatic idle_cycles(input int n);
        clear_slots();
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        put(0, OP_IADD, 0); put(1, OP_IADD, 0); put(2, OP_FADD, 0); put(3, OP_FMUL, 0);
        expect_out("R1 quiet in reset", 4'b0000, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        clear_slots(); put(0, OP_IMUL, 0); put(1, OP_FDIV, 0);
        expect_out("R1 units idle after reset", 4'b0011, 8'b0000_1000);
        idle_cycles(25);
    endtask

    task automatic t_integer();
        @(negedge clk); clear_slots();
        put(0, OP_IADD, 0); put(1, OP_ILOG, 0); put(2, OP_ICMP, 0); put(3, OP_FADD, 0);
        expect_out("R3 E0 then E1, R8 stop", 4'b0011, 8'b0000_0100);
        @(negedge clk); clear_slots();
        put(0, OP_IADD, 0); put(1, OP_SHIFT, 0); put(2, OP_FADD, 0);
        expect_out("R2 E0-only after E0 taken", 4'b0001, 8'h00);
        @(negedge clk); clear_slots();
        put(0, OP_SHIFT, 0); put(1, OP_ICMOV, 0);
        expect_out("R3 fallback to E1", 4'b0011, 8'b0000_0100);
        @(negedge clk); clear_slots();
        put(0, OP_IBR, 0); put(1, OP_IADD, 0); put(2, OP_FADD, 0); put(3, OP_FMUL, 0);
        expect_out("R2 branch on E1 full group", 4'b1111, 8'b11_10_00_01);
        @(negedge clk); clear_slots();
        put(0, OP_CALL, 0); put(1, OP_IBR, 0);
        expect_out("R2 two E1-only", 4'b0001, 8'b0000_0001);
    endtask

    task automatic t_memory();
        @(negedge clk); clear_slots();
        put(0, OP_LOAD, 0); put(1, OP_LOAD, 0); put(2, OP_FADD, 0); put(3, OP_FMUL, 0);
        expect_out("R4 dual load", 4'b1111, 8'b11_10_01_00);
        @(negedge clk); clear_slots();
        put(0, OP_LOAD, 0); put(1, OP_STORE, 0);
        expect_out("R4 load then store", 4'b0001, 8'h00);
        @(negedge clk); clear_slots();
        put(0, OP_STORE, 0); put(1, OP_LOAD, 0);
        expect_out("R4 store then load", 4'b0001, 8'h00);
        @(negedge clk); clear_slots();
        put(0, OP_STORE, 0); put(1, OP_IADD, 0);
        expect_out("R2 store E0 with add", 4'b0011, 8'b0000_0100);
    endtask

    task automatic t_float();
        @(negedge clk); clear_slots();
        put(0, OP_FCPYS, 0); put(1, OP_FCPYS, 0); put(2, OP_FADD, 0);
        expect_out("R5 copy-sign FM then FA", 4'b0011, 8'b0000_1011);
        @(negedge clk); clear_slots();
        put(0, OP_FADD, 0); put(1, OP_FCPYS, 0); put(2, OP_FCPYS, 0);
        expect_out("R5 copy-sign after FA", 4'b0011, 8'b0000_1110);
        @(negedge clk); clear_slots();
        put(0, OP_FCMOV, 0); put(1, OP_FBR, 0);
        expect_out("R5 two FA-only", 4'b0001, 8'b0000_0010);
    endtask

    task automatic t_multi();
        @(negedge clk); clear_slots();
        put(0, OP_MULTI, 0); put(1, OP_IADD, 0);
        expect_out("R6 multi alone", 4'b0001, 8'h00);
        @(negedge clk); clear_slots();
        put(0, OP_FADD, 0); put(1, OP_MULTI, 0);
        expect_out("R6 multi late held", 4'b0001, 8'b0000_0010);
    endtask

    task automatic t_order();
        @(negedge clk); clear_slots();
        put(0, OP_IADD, 0); put(2, OP_FADD, 0); put(3, OP_FMUL, 0);
        expect_out("R8 invalid slot stops", 4'b0001, 8'h00);
        @(negedge clk); clear_slots();
        put(0, 5'd31, 0); put(1, OP_IADD, 0);
        expect_out("R8 unknown class slot0", 4'b0000, 8'h00);
        @(negedge clk); clear_slots();
        put(0, OP_FMUL, 0); put(1, 5'd20, 0); put(2, OP_IADD, 0);
        expect_out("R8 unknown class slot1", 4'b0001, 8'b0000_0011);
    endtask

    task automatic spacing(input string tag, input logic [4:0] c, input logic w,
                           input int hold, input logic [7:0] ep);
        @(negedge clk); clear_slots(); put(0, c, w);
        expect_out({tag, " first"}, 4'b0001, ep);
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            expect_out({tag, " held"}, 4'b0000, 8'h00);
        end
        @(negedge clk);
        expect_out({tag, " reissue"}, 4'b0001, ep);
    endtask

    task automatic t_mul();
        spacing("R7 mul32", OP_IMUL, 1'b0, 4, 8'h00);
        idle_cycles(10);
        spacing("R7 mul64", OP_IMUL, 1'b1, 8, 8'h00);
        idle_cycles(10);
    endtask

    task automatic t_div();
        spacing("R9 div single", OP_FDIV, 1'b0, 15, 8'b0000_0010);
        @(negedge clk); clear_slots();
        put(0, OP_FMUL, 0); put(1, OP_FADD, 0); put(2, OP_FDIV, 0);
        expect_out("R9 other FP while busy", 4'b0011, 8'b0000_1011);
        idle_cycles(25);
        spacing("R9 div double", OP_FDIV, 1'b1, 22, 8'b0000_0010);
        idle_cycles(25);
    endtask

    task automatic t_timer_reset();
        @(negedge clk); clear_slots(); put(0, OP_IMUL, 1);
        expect_out("R7 mul64 before reset", 4'b0001, 8'h00);
        @(negedge clk); rst = 1'b1;
        expect_out("R1 quiet in mid reset", 4'b0000, 8'h00);
        @(negedge clk); rst = 1'b0;
        expect_out("R1 timer cleared by reset", 4'b0001, 8'h00);
        idle_cycles(10);
    endtask

    initial begin
        clear_slots();
        @(negedge clk);
        t_reset();
        t_integer();
        t_memory();
        t_float();
        t_multi();
        t_order();
        t_mul();
        t_div();
        t_timer_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(WATCHDOG_CYC * 5.0);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule